// File: doc/BRIEF.md
# LED String Enable and Feedback Lockout Controller

This block sits between the select pins of a four-string LED backlight driver and its current-sink and feedback circuits. It turns a two-bit select code into a per-string sink-enable mask. It also keeps a per-string lockout record. The record decides which enabled strings may take part in the boost converter's minimum-select feedback loop. The analog feedback and the current regulation are outside this block. It only supplies the masks they consume.

Each time the output overvoltage flag rises, the lockout record is rebuilt. An enabled string that is not in regulation at that moment is locked out of the feedback loop, typically because the string is open. An enabled string that is in regulation is released. A locked-out string still keeps its sink enabled, so it goes on trying to sink its set current. The lockout survives short enable-low intervals. Only the supervisor's clear pulse, issued on a full shutdown, erases it. A separate sticky request collects short-circuit hits from all four pins, including pins whose strings are not selected.

Top module: `string_steer`

## Requirements
- R1: After reset and before the first clock edge that follows it, `sink_en_o`, `fb_mask_o`, `short_fault_o` and `no_reg_o` are all zero, and the lockout record is empty.
- R2: At each rising clock edge, `sink_en_o` takes the thermometer decode of `sel_i`, with bit 0 as the first select pin. Code 0 gives 0001, code 1 gives 0011, code 2 gives 0111 and code 3 gives 1111.
- R3: `ovp_i` passes through a two-stage synchronizer and then an edge detector. A rise of `ovp_i` that is set up before clock edge 1 updates `fb_mask_o` after edge 3 and not earlier. Each string that is enabled and has its `in_reg_i` bit low at that point is removed from `fb_mask_o`.
- R4: A sustained high level on `ovp_i` counts as one event. Changes on `in_reg_i` while `ovp_i` stays high leave `fb_mask_o` unchanged.
- R5: Each new overvoltage event retests every string. An enabled string that is in regulation is restored to `fb_mask_o`. The lock of a string that is not enabled is cleared.
- R6: A locked-out string keeps its `sink_en_o` bit set.
- R7: The lockout record holds across any number of cycles without events. A high `clear_i` empties it at the next clock edge, and `clear_i` takes priority over a coincident event.
- R8: A high bit on `short_i` at any pin, enabled or not, sets `short_fault_o` at the next clock edge. The request stays set after `short_i` falls and is cleared only by `clear_i`, which takes priority.
- R9: `no_reg_o` is high exactly when at least one string is enabled and `fb_mask_o` is zero.
- R10: `fb_mask_o` is always a subset of `sink_en_o`. A string disabled through `sel_i` leaves both masks at the next clock edge. The select pins do not change lockout bits, so a locked string that is later re-enabled comes back still locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | String select code, bit 0 is the first select pin |
| in_reg_i | input | 4 | Per-string in-regulation flag |
| short_i | input | 4 | Per-pin short-threshold flag |
| ovp_i | input | 1 | Output overvoltage flag, asynchronous |
| clear_i | input | 1 | Shutdown clear pulse from the supervisor |
| sink_en_o | output | 4 | Sink-enable mask |
| fb_mask_o | output | 4 | Feedback-participation mask |
| short_fault_o | output | 1 | Sticky short-fault request |
| no_reg_o | output | 1 | No enabled string is left in the feedback loop |

## Verification
A corrupted lockout bit shows up at once in `fb_mask_o` as a string that is missing or present against the expected mask. It persists until the next overvoltage event or clear rewrites the record. For this reason the bench compares the mask after each event and again after long idle gaps. An error in the synchronizer or the edge detector moves the mask update away from the third edge, or lets one held event fire twice. Both effects are visible on the exact cycle the bench samples. A lost short latch drops `short_fault_o` on the first cycle after `short_i` falls.

// File: rtl/string_steer_pkg.sv
package string_steer_pkg;

  localparam int unsigned MASK_W_MAX = 32;

  // Mask with the lowest cnt bits set (saturates at MASK_W_MAX).
  function automatic logic [MASK_W_MAX-1:0] therm_mask(int unsigned cnt);
    logic [MASK_W_MAX-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < MASK_W_MAX; k++) begin
      m[k] = (k < cnt);
    end
    return m;
  endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int N_STR = 4,
  localparam int SEL_W = (N_STR > 1) ? $clog2(N_STR) : 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_STR-1:0] en_o
);

  for (genvar k = 0; k < N_STR; k++) begin : g_bit
    if (k == 0) begin : g_first
      assign en_o[k] = 1'b1;
    end else begin : g_rest
      assign en_o[k] = ({1'b0, sel_i} >= (SEL_W+1)'(k));
    end
  end

endmodule

// File: rtl/ovp_edge.sv
module ovp_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/lockout_reg.sv
module lockout_reg #(
  parameter int N_STR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clear_i,
  input  logic [N_STR-1:0] en_i,
  input  logic [N_STR-1:0] in_reg_i,
  output logic [N_STR-1:0] lock_o
);

  for (genvar k = 0; k < N_STR; k++) begin : g_str
    logic lock_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lock_q <= 1'b0;
      else if (clear_i) lock_q <= 1'b0;
      else if (evt_i)   lock_q <= en_i[k] & ~in_reg_i[k]; // full retest
    end
    assign lock_o[k] = lock_q;
  end

endmodule

// File: rtl/string_steer.sv
module string_steer
  import string_steer_pkg::*;
#(
  parameter int N_STR       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (N_STR > 1) ? $clog2(N_STR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_STR-1:0] in_reg_i,
  input  logic [N_STR-1:0] short_i,
  input  logic             ovp_i,
  input  logic             clear_i,
  output logic [N_STR-1:0] sink_en_o,
  output logic [N_STR-1:0] fb_mask_o,
  output logic             short_fault_o,
  output logic             no_reg_o
);

  logic [N_STR-1:0] en_d;
  logic [N_STR-1:0] sink_q;
  logic [N_STR-1:0] lock_q;
  logic             ovp_evt;
  logic             short_q;

  sel_decode #(.N_STR(N_STR)) u_dec (
    .sel_i (sel_i),
    .en_o  (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sink_q <= '0;
    else         sink_q <= en_d;
  end

  ovp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ovp_i),
    .rise_o  (ovp_evt)
  );

  lockout_reg #(.N_STR(N_STR)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (ovp_evt),
    .clear_i  (clear_i),
    .en_i     (sink_q),
    .in_reg_i (in_reg_i),
    .lock_o   (lock_q)
  );

  // Short request covers every pin, selected or not.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        short_q <= 1'b0;
    else if (clear_i)   short_q <= 1'b0;
    else if (|short_i)  short_q <= 1'b1;
  end

  assign sink_en_o     = sink_q;
  assign fb_mask_o     = sink_q & ~lock_q;
  assign short_fault_o = short_q;
  assign no_reg_o      = (|sink_q) & ~(|fb_mask_o);

endmodule

// File: rtl/string_steer_chk.sv
module string_steer_chk
  import string_steer_pkg::*;
#(
  parameter int N_STR = 4,
  localparam int SEL_W = (N_STR > 1) ? $clog2(N_STR) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic [N_STR-1:0] in_reg_i,
  input logic [N_STR-1:0] short_i,
  input logic             clear_i,
  input logic [N_STR-1:0] sink_en_o,
  input logic [N_STR-1:0] fb_mask_o,
  input logic             short_fault_o,
  input logic             no_reg_o,
  input logic             evt_i,
  input logic [N_STR-1:0] lock_i
);

  p_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> sink_en_o == N_STR'(therm_mask(int'($past(sel_i)) + 1)));

  p_lock_update_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clear_i) |=> lock_i == $past(sink_en_o & ~in_reg_i));

  p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clear_i) |=> $stable(lock_i));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (lock_i == '0 && !short_fault_o));

  p_short_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|short_i && !clear_i) |=> short_fault_o);

  p_short_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_fault_o && !clear_i) |=> short_fault_o);

  p_no_reg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_reg_o |-> (fb_mask_o == '0 && sink_en_o != '0));

  p_subset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_mask_o & ~sink_en_o) == '0);

  p_locked_sinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fb_mask_o[0]) && $stable(sink_en_o) |-> sink_en_o[0]);

endmodule

bind string_steer string_steer_chk #(.N_STR(N_STR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_i         (sel_i),
  .in_reg_i      (in_reg_i),
  .short_i       (short_i),
  .clear_i       (clear_i),
  .sink_en_o     (sink_en_o),
  .fb_mask_o     (fb_mask_o),
  .short_fault_o (short_fault_o),
  .no_reg_o      (no_reg_o),
  .evt_i         (ovp_evt),
  .lock_i        (lock_q)
);

// File: tb/string_steer_bench.sv
module string_steer_bench;

  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sel_i = '0;
  logic [3:0] in_reg_i = '0;
  logic [3:0] short_i = '0;
  logic       ovp_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [3:0] sink_en_o, fb_mask_o;
  logic       short_fault_o, no_reg_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  string_steer u_string_steer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .in_reg_i(in_reg_i),
    .short_i(short_i), .ovp_i(ovp_i), .clear_i(clear_i),
    .sink_en_o(sink_en_o), .fb_mask_o(fb_mask_o),
    .short_fault_o(short_fault_o), .no_reg_o(no_reg_o)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // Advance n edges; leaves time just after the last edge.
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
    end
    #1;
  endtask

  task automatic drive_edge();
    @(negedge clk_i);
  endtask

  task automatic ovp_pulse();
    drive_edge(); ovp_i = 1'b1;
    tick(3);
    drive_edge(); ovp_i = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    #2;
    chk("R1 sink", sink_en_o, 4'b0000);
    chk("R1 fb", fb_mask_o, 4'b0000);
    chk("R1 flags", {2'b00, short_fault_o, no_reg_o}, 4'b0000);
    drive_edge(); rst_ni = 1'b1;
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      drive_edge(); sel_i = 2'(s);
      tick(1);
      chk("R2 sink", sink_en_o, 4'((1 << (s + 1)) - 1));
      chk("R2 fb", fb_mask_o, 4'((1 << (s + 1)) - 1));
    end
  endtask

  task automatic t_lock();
    drive_edge(); sel_i = 2'd3; in_reg_i = 4'b1010; ovp_i = 1'b1;
    tick(2);
    chk("R3 early", fb_mask_o, 4'b1111);
    tick(1);
    chk("R3 lock", fb_mask_o, 4'b1010);
    chk("R6 sink kept", sink_en_o, 4'b1111);
    drive_edge(); in_reg_i = 4'b1111;
    tick(6);
    chk("R4 held once", fb_mask_o, 4'b1010);
    drive_edge(); ovp_i = 1'b0; in_reg_i = 4'b0011;
    tick(3);
    ovp_pulse();
    chk("R5 retest", fb_mask_o, 4'b0011);
    chk("R9 off", {3'b000, no_reg_o}, 4'b0000);
  endtask

  task automatic t_sel();
    drive_edge(); sel_i = 2'd1;
    tick(1);
    chk("R10 sink", sink_en_o, 4'b0011);
    chk("R10 fb", fb_mask_o, 4'b0011);
    drive_edge(); sel_i = 2'd0;
    tick(1);
    chk("R10 fb one", fb_mask_o, 4'b0001);
    drive_edge(); sel_i = 2'd3;
    tick(1);
    chk("R10 relock", fb_mask_o, 4'b0011);
  endtask

  task automatic t_noreg();
    drive_edge(); in_reg_i = 4'b0000;
    ovp_pulse();
    chk("R9 fb empty", fb_mask_o, 4'b0000);
    chk("R9 flag", {3'b000, no_reg_o}, 4'b0001);
    drive_edge(); sel_i = 2'd0;
    tick(1);
    ovp_pulse();
    drive_edge(); sel_i = 2'd3; in_reg_i = 4'b1111;
    tick(1);
    chk("R5 disabled cleared", fb_mask_o, 4'b1110);
  endtask

  task automatic t_clear();
    tick(50);
    chk("R7 hold", fb_mask_o, 4'b1110);
    drive_edge(); clear_i = 1'b1; in_reg_i = 4'b0000; ovp_i = 1'b1;
    tick(1);
    drive_edge(); clear_i = 1'b0;
    tick(1);
    chk("R7 cleared", fb_mask_o, 4'b1111);
    drive_edge(); ovp_i = 1'b0; in_reg_i = 4'b1111;
    tick(4);
  endtask

  task automatic t_short();
    drive_edge(); sel_i = 2'd0; short_i = 4'b1000;
    tick(1);
    chk("R8 set", {3'b000, short_fault_o}, 4'b0001);
    drive_edge(); short_i = 4'b0000;
    tick(5);
    chk("R8 sticky", {3'b000, short_fault_o}, 4'b0001);
    drive_edge(); clear_i = 1'b1; short_i = 4'b0010;
    tick(1);
    chk("R8 clear wins", {3'b000, short_fault_o}, 4'b0000);
    drive_edge(); clear_i = 1'b0; short_i = 4'b0000;
    tick(2);
    chk("R8 stays clear", {3'b000, short_fault_o}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_lock();
    t_sel();
    t_noreg();
    t_clear();
    t_short();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule